// File: doc/BRIEF.md
# Two-Tap Modulation Sequencer

This block decides, for every cycle of an oscillator clock, whether that cycle runs on a base tap setting or on the tap just above it. The cycles are grouped into frames of 32. In each frame exactly MOD cycles use the higher tap and the other 32−MOD cycles use the base tap. The average frequency over a frame is therefore (f_base·(32−MOD) + f_next·MOD)/32. The higher-tap cycles are spread as evenly as possible across the frame rather than bunched together, which keeps the short-term deviation from the average small.

A 5-bit phase accumulator adds MOD on every cycle. A cycle uses the higher tap when that addition carries out. Over 32 additions the accumulator returns to zero after exactly MOD carries. The MOD and base-tap inputs are captured only on the first edge of each frame. A change that arrives mid-frame therefore takes effect cleanly at the next frame, and within a frame the output can only move between two adjacent taps. When the base tap is already the highest tap, the higher selection saturates at that tap.

The control is a three-state machine. ST_BOOT is held in reset. On the first edge of every frame the block leaves for ST_FLAT when the captured MOD is zero or the captured tap is the maximum, and for ST_DITHER otherwise. The state otherwise stays put within a frame. Those boundary transitions are ST_BOOT→ST_FLAT, ST_BOOT→ST_DITHER, ST_FLAT→ST_DITHER, ST_DITHER→ST_FLAT, and the self-loops on ST_FLAT and ST_DITHER. Reset sends any state back to ST_BOOT.

Top module: `tap_dither_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge (synchronous reset), tap_out becomes 0, whatever mod_in and tap_in hold.
- R2: When the captured base tap is below the maximum, each frame of 32 consecutive output cycles has exactly MOD cycles at base+1 and 32−MOD cycles at the base tap.
- R3: With a captured MOD of 0, tap_out equals the captured base tap on every cycle of the frame.
- R4: The output for cycle j (j = 1..32 within a frame) is base+1 exactly when floor(j·MOD/32) > floor((j−1)·MOD/32), and the base tap otherwise.
- R5: Frames are aligned to reset. The first rising edge after rst_n goes high starts frame 0, and frame k covers the outputs produced by edges 32k+1 to 32k+32. mod_in and tap_in are sampled only on the first edge of a frame, and the output of that same edge already uses them.
- R6: A change of mod_in after the first edge of a frame has no effect on that frame's outputs. The new value applies from the next frame.
- R7: A change of tap_in after the first edge of a frame has no effect on that frame. Within a frame tap_out only takes the captured base tap or the tap one above it.
- R8: When the captured base tap is the maximum (all ones), tap_out stays at the maximum for the whole frame for any MOD.
- R9: With MOD = 31, only cycle 1 of the frame uses the base tap and the remaining 31 cycles use base+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_in | input | MOD_W (5) | Number of higher-tap cycles per frame |
| tap_in | input | TAP_W (5) | Base tap setting |
| tap_out | output | TAP_W (5) | Tap to use for the current cycle (registered) |

## Verification
The sequence is tried with MOD values 0, 1, 5, 16, 17 and 31, and every cycle of the frame is compared with the floor-difference rule. A wrong count, a bunched placement and a frame misaligned by one cycle each give a different output. MOD 16 against 17 shows whether the accumulator wraps correctly past half scale. MOD 31 shows whether the first cycle of a frame is the single low one. Frames in which mod_in or tap_in changes halfway show whether values are captured only at the boundary, and the following frame shows that the new value then takes over. A base tap of 31 checks the saturation, and a second reset in the middle of a run checks that frame alignment restarts.

// File: rtl/tap_dither_pkg.sv
package tap_dither_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_FLAT   = 2'd1,
        ST_DITHER = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tap_dither_phase.sv
module tap_dither_phase #(
    parameter int unsigned PHASE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase_q,
    output logic               frame_start
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign frame_start = (phase_q == '0);

endmodule

// File: rtl/tap_dither_latch.sv
module tap_dither_latch #(
    parameter int unsigned MOD_W = 5,
    parameter int unsigned TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MOD_W-1:0] mod_in,
    input  logic [TAP_W-1:0] tap_in,
    output logic [MOD_W-1:0] mod_q,
    output logic [TAP_W-1:0] tap_q,
    output logic [MOD_W-1:0] mod_eff,
    output logic [TAP_W-1:0] tap_eff
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            tap_q <= '0;
        end else if (load) begin
            mod_q <= mod_in;
            tap_q <= tap_in;
        end
    end

    // Values that govern the cycle being produced at this edge
    assign mod_eff = load ? mod_in : mod_q;
    assign tap_eff = load ? tap_in : tap_q;

endmodule

// File: rtl/tap_dither_accum.sv
module tap_dither_accum #(
    parameter int unsigned ACC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [ACC_W-1:0] step,
    output logic             carry
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   sum;

    assign base  = restart ? '0 : acc_q;
    assign sum   = {1'b0, base} + {1'b0, step};
    assign carry = sum[ACC_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/tap_dither_step.sv
module tap_dither_step #(
    parameter int unsigned TAP_W = 5
) (
    input  logic [TAP_W-1:0] base_tap,
    input  logic             go_up,
    output logic [TAP_W-1:0] sel_tap
);

    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    always_comb begin
        if (go_up && (base_tap != TAP_MAX)) begin
            sel_tap = base_tap + 1'b1;
        end else begin
            sel_tap = base_tap;
        end
    end

endmodule

// File: rtl/tap_dither_seq.sv
module tap_dither_seq
    import tap_dither_pkg::*;
#(
    parameter int unsigned MOD_W = 5,
    parameter int unsigned TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] mod_in,
    input  logic [TAP_W-1:0] tap_in,
    output logic [TAP_W-1:0] tap_out
);

    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    logic [MOD_W-1:0] phase_q;
    logic             frame_start;
    logic [MOD_W-1:0] mod_q;
    logic [TAP_W-1:0] tap_q;
    logic [MOD_W-1:0] mod_eff;
    logic [TAP_W-1:0] tap_eff;
    logic             carry;
    logic [TAP_W-1:0] up_tap;
    logic [TAP_W-1:0] tap_d;
    seq_state_e       state_q;
    seq_state_e       state_d;

    tap_dither_phase #(.PHASE_W(MOD_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_q     (phase_q),
        .frame_start (frame_start)
    );

    tap_dither_latch #(.MOD_W(MOD_W), .TAP_W(TAP_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_start),
        .mod_in  (mod_in),
        .tap_in  (tap_in),
        .mod_q   (mod_q),
        .tap_q   (tap_q),
        .mod_eff (mod_eff),
        .tap_eff (tap_eff)
    );

    tap_dither_accum #(.ACC_W(MOD_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .step    (mod_eff),
        .carry   (carry)
    );

    tap_dither_step #(.TAP_W(TAP_W)) u_step (
        .base_tap (tap_eff),
        .go_up    (carry),
        .sel_tap  (up_tap)
    );

    // Next-state logic: the mode changes only at a frame boundary
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            if ((mod_eff == '0) || (tap_eff == TAP_MAX)) begin
                state_d = ST_FLAT;
            end else begin
                state_d = ST_DITHER;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode for the cycle being produced
    always_comb begin
        unique case (state_d)
            ST_BOOT:   tap_d = '0;
            ST_FLAT:   tap_d = tap_eff;
            ST_DITHER: tap_d = up_tap;
            default:   tap_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_out <= '0;
        end else begin
            tap_out <= tap_d;
        end
    end

endmodule

// File: rtl/tap_dither_seq_chk.sv
module tap_dither_seq_chk
    import tap_dither_pkg::*;
#(
    parameter int unsigned MOD_W = 5,
    parameter int unsigned TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MOD_W-1:0] phase_q,
    input logic [MOD_W-1:0] mod_q,
    input logic [TAP_W-1:0] tap_q,
    input logic [TAP_W-1:0] tap_out,
    input seq_state_e       state_q
);

    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    logic             in_rst_q;
    logic             seen_q;
    logic [MOD_W:0]   hi_acc;
    logic             is_hi;
    logic [MOD_W:0]   hi_total;
    logic [TAP_W-1:0] up_ref;

    assign is_hi    = (tap_out != tap_q);
    assign hi_total = hi_acc + {{MOD_W{1'b0}}, is_hi};
    assign up_ref   = (tap_q == TAP_MAX) ? TAP_MAX : tap_q + 1'b1;

    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
        if (!rst_n) begin
            seen_q <= 1'b0;
            hi_acc <= '0;
        end else begin
            if (phase_q == {{(MOD_W-1){1'b0}}, 1'b1}) begin
                seen_q <= 1'b1;
                hi_acc <= {{MOD_W{1'b0}}, is_hi};
            end else begin
                hi_acc <= hi_total;
            end
        end
    end

    always @(negedge clk) begin
        if (in_rst_q) begin
            AST_RESET_ZERO: assert (tap_out == '0); // R1
        end
    end

    AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (phase_q == '0) && (tap_q != TAP_MAX)) |-> (hi_total == {1'b0, mod_q})); // R2

    AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_q == '0) |-> (tap_out == tap_q)); // R3

    AST_HOLD_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != '0) |=> $stable(mod_q)); // R6

    AST_TWO_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_out == tap_q) || (tap_out == up_ref)); // R7

    AST_CLAMP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_q == TAP_MAX) |-> (tap_out == TAP_MAX)); // R8

    AST_NO_REBOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT) |=> (state_q != ST_BOOT)); // R5

endmodule

bind tap_dither_seq tap_dither_seq_chk #(.MOD_W(MOD_W), .TAP_W(TAP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_q (phase_q),
    .mod_q   (mod_q),
    .tap_q   (tap_q),
    .tap_out (tap_out),
    .state_q (state_q)
);

// File: tb/sim_tap_dither_seq.sv
`timescale 1ns/1ps
module sim_tap_dither_seq;

    localparam int MW = 5;
    localparam int TW = 5;
    localparam int FRAME = 32;
    localparam int TMAX = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] mod_in = '0;
    logic [TW-1:0] tap_in = '0;
    logic [TW-1:0] tap_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tap_dither_seq #(.MOD_W(MW), .TAP_W(TW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_in  (mod_in),
        .tap_in  (tap_in),
        .tap_out (tap_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit want_hi(input int j, input int m);
        return ((j * m) / FRAME) > (((j - 1) * m) / FRAME);
    endfunction

    // One frame; inputs set before its first edge, optional mid-frame change
    task automatic run_frame(input int m, input int t, input int chg_at,
                             input int new_m, input int new_t, input string req);
        int up;
        int hits;
        int bad;
        int first_bad_act;
        int first_bad_exp;
        up = (t == TMAX) ? TMAX : t + 1;
        hits = 0;
        bad = 0;
        first_bad_act = 0;
        first_bad_exp = 0;
        mod_in = m[MW-1:0];
        tap_in = t[TW-1:0];
        for (int j = 1; j <= FRAME; j++) begin
            int exp_tap;
            @(posedge clk);
            @(negedge clk);
            exp_tap = want_hi(j, m) ? up : t;
            if ((int'(tap_out) == up) && (up != t)) hits++;
            if (int'(tap_out) != exp_tap) begin
                if (bad == 0) begin
                    first_bad_act = int'(tap_out);
                    first_bad_exp = exp_tap;
                end
                bad++;
            end
            if (j == chg_at) begin
                mod_in = new_m[MW-1:0];
                tap_in = new_t[TW-1:0];
            end
        end
        check(bad == 0, {req, " per-cycle pattern (R4)"}, first_bad_act, first_bad_exp);
        check(hits == ((up != t) ? m : 0), {req, " higher-tap count (R2)"}, hits, (up != t) ? m : 0);
    endtask

    task automatic t_reset(input string req);
        rst_n = 1'b0;
        mod_in = 5'd16;
        tap_in = 5'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tap_out == '0, req, int'(tap_out), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset("R1 reset output");
        // R5: the first frame after reset starts at the first edge
        run_frame(5, 12, 0, 0, 0, "R5 first frame alignment");
        run_frame(0, 7, 0, 0, 0, "R3 mod zero flat");
        run_frame(1, 3, 0, 0, 0, "R4 mod one");
        run_frame(16, 20, 0, 0, 0, "R4 mod sixteen");
        run_frame(17, 20, 0, 0, 0, "R4 mod seventeen");
        run_frame(31, 0, 0, 0, 0, "R9 mod max");
        run_frame(13, 31, 0, 0, 0, "R8 clamp at top tap");
        run_frame(30, 30, 0, 0, 0, "R8 tap one below top");
        // R6: mod_in changes mid-frame, the next frame takes it
        run_frame(5, 14, 10, 20, 14, "R6 mid-frame mod change");
        run_frame(20, 14, 0, 0, 0, "R6 new mod next frame");
        // R7: tap_in changes mid-frame
        run_frame(9, 10, 4, 9, 3, "R7 mid-frame tap change");
        run_frame(9, 3, 0, 0, 0, "R7 new tap next frame");
        // Reset in mid-run, then realignment
        run_frame(7, 4, 12, 7, 4, "R2 before second reset");
        t_reset("R1 second reset");
        run_frame(11, 6, 0, 0, 0, "R5 realigned after reset");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule